// File: doc/BRIEF.md
# Self-Test Session Sequencer with Stimulus Selector

This block runs one self-test session around a sequential unit under test whose flip-flops are left as they are and tested in place. While the test request input is low, the unit under test sees its ordinary functional inputs. When the request goes high, the sequencer resets the external pattern generator and the unit under test together. It then steers the generator's output onto the unit's inputs. The generator is advanced on every clock of a fixed-length window with no gaps, so the unit sees the vectors exactly in generation order.

During that window the unit's outputs are folded into an on-block multiple-input signature register. One cycle after the window closes, the signature is compared with a golden constant fixed at build time. The session then shows a done flag together with a pass/fail bit, and keeps both until the request is withdrawn. Withdrawing the request at any point abandons the session and hands the inputs back to the functional path.

Top module: `bist_session_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the block is idle. `uutIn` equals `priIn`, and `genSeed`, `uutSeed`, `genRun`, `done` and `good` are all 0.
- R2: While idle, `uutIn` follows `priIn` in the same cycle.
- R3: A clock edge that samples `testMode` high while idle opens exactly one seed cycle. In that cycle `genSeed` and `uutSeed` are 1, `genRun` is 0 and `uutIn` equals `genPat`.
- R4: After the seed cycle, `genRun` is 1 for exactly SESSION_LEN consecutive cycles with no gap, and `uutIn` equals `genPat` throughout.
- R5: The signature is cleared to 0 in the seed cycle. On each edge that ends a `genRun` cycle it becomes `({sig[OUT_W-2:0],1'b0} ^ (sig[OUT_W-1] ? SIG_POLY : 0)) ^ uutOut`. In every other cycle it holds, so `uutOut` has no effect outside the run window.
- R6: One compare cycle follows the run window, during which `done` is 0. From the next cycle on, `done` is 1 and `good` is 1 exactly when the final signature equals GOLDEN_SIG.
- R7: While `testMode` stays high, `done` and `good` hold their values, and `uutIn` keeps carrying `genPat`.
- R8: An edge that samples `testMode` low in any state returns the block to idle on the next cycle. `uutIn` equals `priIn` again, all strobes and `done` are 0, and a later rise of `testMode` starts a complete new session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| testMode | input | 1 | High requests a test session; low selects normal operation |
| priIn | input | IN_W | Functional inputs for the unit under test |
| genPat | input | IN_W | Current vector from the pattern generator |
| uutOut | input | OUT_W | Responses of the unit under test |
| uutIn | output | IN_W | Inputs driven to the unit under test |
| genSeed | output | 1 | Loads the generator's start state |
| genRun | output | 1 | Advances the generator by one step |
| uutSeed | output | 1 | Resets the unit under test's state |
| done | output | 1 | Session finished, result valid |
| good | output | 1 | Pass (1) or fail (0), valid while done is 1 |

## Verification
The bench builds the block with an 8-bit input path, a 6-bit signature, polynomial 0x21 and a 40-cycle session. A whole session therefore takes a few dozen cycles, which leaves room for several sessions in one run: a clean pass, a single-cycle response fault that must flip the verdict, and an abort in mid-window followed by a full restart. The golden constant is derived in the bench from its own generator and unit models. The short window also exercises the counter's final value and the run-to-compare hand-off at a point that is easy to reach.

// File: rtl/bist_sess_pkg.sv
package bist_sess_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_RUN,
    ST_CMP,
    ST_DONE
  } sessState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic selGen;    // steer generator vectors to the unit under test
    logic clearSig;  // seed cycle: clear signature, reset generator and unit
    logic capture;   // run cycle: fold responses, advance generator
    logic latchRes;  // compare cycle: record the verdict
    logic showRes;   // done: present the verdict
  } sessStrobe_t;

endpackage

// File: rtl/bist_sess_ctrl.sv
module bist_sess_ctrl
  import bist_sess_pkg::*;
#(
  parameter int SESSION_LEN = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        testMode,
  output sessStrobe_t strb
);

  localparam int CNT_W = (SESSION_LEN > 1) ? $clog2(SESSION_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SESSION_LEN - 1);

  sessState_e state, stateNxt;
  logic [CNT_W-1:0] cycCnt;

  always_comb begin
    stateNxt = state;
    if (!testMode) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: stateNxt = ST_SEED;
        ST_SEED: stateNxt = ST_RUN;
        ST_RUN:  stateNxt = (cycCnt == LAST_CNT) ? ST_CMP : ST_RUN;
        ST_CMP:  stateNxt = ST_DONE;
        ST_DONE: stateNxt = ST_DONE;
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cycCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_RUN) cycCnt <= cycCnt + 1'b1;
      else                 cycCnt <= '0;
    end
  end

  always_comb begin
    strb          = '0;
    strb.selGen   = (state != ST_IDLE);
    strb.clearSig = (state == ST_SEED);
    strb.capture  = (state == ST_RUN);
    strb.latchRes = (state == ST_CMP);
    strb.showRes  = (state == ST_DONE);
  end

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |=> state == ST_IDLE); // R8
  AST_START_SEEDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && testMode) |=> state == ST_SEED); // R3
  AST_SEED_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SEED |=> state != ST_SEED); // R3
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RUN |-> cycCnt <= LAST_CNT); // R4
  AST_RUN_NO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && cycCnt != LAST_CNT && testMode) |=> state == ST_RUN); // R4
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && testMode) |=> state == ST_DONE); // R7

endmodule

// File: rtl/bist_sig_reg.sv
module bist_sig_reg #(
  parameter int               OUT_W    = 16,
  parameter logic [OUT_W-1:0] SIG_POLY = OUT_W'(16'h100B)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             capture,
  input  logic [OUT_W-1:0] resp,
  output logic [OUT_W-1:0] sig
);

  logic [OUT_W-1:0] shifted;

  always_comb begin
    shifted = {sig[OUT_W-2:0], 1'b0};
    if (sig[OUT_W-1]) shifted = shifted ^ SIG_POLY;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        sig <= '0;
    else if (clear)   sig <= '0;
    else if (capture) sig <= shifted ^ resp;
  end

  AST_SIG_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> sig == '0); // R5
  AST_SIG_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !capture) |=> $stable(sig)); // R5

endmodule

// File: rtl/bist_sess_dp.sv
module bist_sess_dp
  import bist_sess_pkg::*;
#(
  parameter int               IN_W       = 32,
  parameter int               OUT_W      = 16,
  parameter logic [OUT_W-1:0] SIG_POLY   = OUT_W'(16'h100B),
  parameter logic [OUT_W-1:0] GOLDEN_SIG = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  sessStrobe_t      strb,
  input  logic [IN_W-1:0]  priIn,
  input  logic [IN_W-1:0]  genPat,
  input  logic [OUT_W-1:0] uutOut,
  output logic [IN_W-1:0]  uutIn,
  output logic             good
);

  logic [OUT_W-1:0] sigQ;
  logic             goodReg;

  assign uutIn = strb.selGen ? genPat : priIn;

  bist_sig_reg #(
    .OUT_W   (OUT_W),
    .SIG_POLY(SIG_POLY)
  ) u_sig (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (strb.clearSig),
    .capture(strb.capture),
    .resp   (uutOut),
    .sig    (sigQ)
  );

  always_ff @(posedge clk) begin
    if (!rstN)              goodReg <= 1'b0;
    else if (strb.clearSig) goodReg <= 1'b0;
    else if (strb.latchRes) goodReg <= (sigQ == GOLDEN_SIG);
  end

  assign good = strb.showRes & goodReg;

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.showRes && $past(strb.showRes)) |-> $stable(goodReg)); // R7
  AST_NO_VERDICT_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.showRes |-> !good); // R6

endmodule

// File: rtl/bist_session_ctrl.sv
module bist_session_ctrl
  import bist_sess_pkg::*;
#(
  parameter int               IN_W        = 32,
  parameter int               OUT_W       = 16,
  parameter int               SESSION_LEN = 10000,
  parameter logic [OUT_W-1:0] SIG_POLY    = OUT_W'(16'h100B),
  parameter logic [OUT_W-1:0] GOLDEN_SIG  = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             testMode,
  input  logic [IN_W-1:0]  priIn,
  input  logic [IN_W-1:0]  genPat,
  input  logic [OUT_W-1:0] uutOut,
  output logic [IN_W-1:0]  uutIn,
  output logic             genSeed,
  output logic             genRun,
  output logic             uutSeed,
  output logic             done,
  output logic             good
);

  sessStrobe_t strb;

  bist_sess_ctrl #(
    .SESSION_LEN(SESSION_LEN)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .testMode(testMode),
    .strb    (strb)
  );

  bist_sess_dp #(
    .IN_W      (IN_W),
    .OUT_W     (OUT_W),
    .SIG_POLY  (SIG_POLY),
    .GOLDEN_SIG(GOLDEN_SIG)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .priIn (priIn),
    .genPat(genPat),
    .uutOut(uutOut),
    .uutIn (uutIn),
    .good  (good)
  );

  assign genSeed = strb.clearSig;
  assign uutSeed = strb.clearSig;
  assign genRun  = strb.capture;
  assign done    = strb.showRes;

endmodule

// File: tb/sim_bist_session_ctrl.sv
`timescale 1ns/1ps
module sim_bist_session_ctrl;

  localparam int IN_W  = 8;
  localparam int OUT_W = 6;
  localparam int LEN   = 40;
  localparam logic [OUT_W-1:0] POLY     = 6'h21;
  localparam logic [IN_W-1:0]  GEN_INIT = 8'h5A;

  function automatic logic [IN_W-1:0] lfsrNext(input logic [IN_W-1:0] g);
    return {g[6:0], g[7] ^ g[5] ^ g[4] ^ g[3]};
  endfunction

  function automatic logic [OUT_W-1:0] sigStep(input logic [OUT_W-1:0] s,
                                               input logic [OUT_W-1:0] r);
    logic [OUT_W-1:0] t;
    t = s << 1;
    if (s[OUT_W-1]) t = t ^ POLY;
    return t ^ r;
  endfunction

  function automatic logic [OUT_W-1:0] calcGolden();
    logic [IN_W-1:0]  g;
    logic [IN_W-1:0]  u;
    logic [OUT_W-1:0] s;
    g = GEN_INIT; u = '0; s = '0;
    for (int k = 0; k < LEN; k++) begin
      s = sigStep(s, u[OUT_W-1:0]);
      u = u ^ g;
      g = lfsrNext(g);
    end
    return s;
  endfunction

  localparam logic [OUT_W-1:0] GOLD = calcGolden();

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testMode = 1'b0;
  logic [IN_W-1:0]  priIn = '0;
  logic [OUT_W-1:0] faultMask = '0;
  logic [IN_W-1:0]  genReg;
  logic [IN_W-1:0]  uutReg;
  logic [OUT_W-1:0] uutOut;
  logic [IN_W-1:0]  uutIn;
  logic genSeed, genRun, uutSeed, done, good;

  int nChk = 0;
  int nErr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bist_session_ctrl #(
    .IN_W(IN_W), .OUT_W(OUT_W), .SESSION_LEN(LEN),
    .SIG_POLY(POLY), .GOLDEN_SIG(GOLD)
  ) u0 (
    .clk(clk), .rstN(rstN), .testMode(testMode), .priIn(priIn),
    .genPat(genReg), .uutOut(uutOut), .uutIn(uutIn), .genSeed(genSeed),
    .genRun(genRun), .uutSeed(uutSeed), .done(done), .good(good)
  );

  // environment: pattern generator and a small sequential unit under test
  always_ff @(posedge clk) begin
    if (genSeed)     genReg <= GEN_INIT;
    else if (genRun) genReg <= lfsrNext(genReg);
    if (!rstN || uutSeed) uutReg <= '0;
    else                  uutReg <= uutReg ^ uutIn;
  end
  assign uutOut = uutReg[OUT_W-1:0] ^ faultMask;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle reference model, phases: 0 idle 1 seed 2 run 3 compare 4 done
  int mPh = 0;
  int mCnt = 0;
  logic [OUT_W-1:0] mSig = '0;
  bit mGood = 0;

  always @(negedge clk) begin
    if (rstN) begin
      chk(uutIn === ((mPh != 0) ? genReg : priIn), (mPh == 0) ? "R2" : "R4",
          32'(uutIn), 32'((mPh != 0) ? genReg : priIn));
      chk(genSeed === (mPh == 1), "R3", 32'(genSeed), 32'(mPh == 1));
      chk(uutSeed === (mPh == 1), "R3", 32'(uutSeed), 32'(mPh == 1));
      chk(genRun === (mPh == 2), "R4", 32'(genRun), 32'(mPh == 2));
      chk(done === (mPh == 4), "R7", 32'(done), 32'(mPh == 4));
      chk(good === (mPh == 4 && mGood), "R6", 32'(good), 32'(mPh == 4 && mGood));
    end
    if (!rstN) begin
      mPh = 0; mSig = '0; mGood = 0;
    end else begin
      if (mPh == 1) begin mSig = '0; mGood = 0; end
      if (mPh == 2) mSig = sigStep(mSig, uutOut);
      if (mPh == 3) mGood = (mSig == GOLD);
      if (!testMode) mPh = 0;
      else case (mPh)
        0: mPh = 1;
        1: begin mPh = 2; mCnt = 0; end
        2: if (mCnt == LEN - 1) mPh = 3; else mCnt++;
        3: mPh = 4;
        default: ;
      endcase
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 200; i++) begin
      if (done) break;
      tick();
    end
  endtask

  task automatic waitRun();
    for (int i = 0; i < 20; i++) begin
      if (genRun) break;
      tick();
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nErr++;
    nChk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish();
  end

  initial begin
    priIn = 8'hC3;
    repeat (3) tick();
    // R1: reset state
    chk(uutIn === 8'hC3, "R1", 32'(uutIn), 32'hC3);
    chk({genSeed, genRun, uutSeed, done, good} === 5'b0, "R1",
        32'({genSeed, genRun, uutSeed, done, good}), 0);
    rstN = 1'b1;
    tick();
    chk({genSeed, genRun, uutSeed, done, good} === 5'b0, "R1",
        32'({genSeed, genRun, uutSeed, done, good}), 0);

    // R2: functional path in idle, with varied inputs and response noise
    for (int i = 0; i < 6; i++) begin
      priIn = 8'(i * 37 + 5);
      faultMask = 6'(i * 11);
      #0.5;
      chk(uutIn === priIn, "R2", 32'(uutIn), 32'(priIn));
      tick();
    end
    faultMask = '0;

    // session 1: clean run
    testMode = 1'b1;
    tick();
    chk(genSeed && uutSeed && !genRun, "R3", 32'({genSeed, uutSeed, genRun}), 3'b110);
    waitDone();
    chk(done === 1'b1, "R6", 32'(done), 1);
    chk(good === 1'b1, "R6", 32'(good), 1);
    // R5: responses outside the run window have no effect
    faultMask = 6'h3F;
    repeat (4) tick();
    chk(good === 1'b1 && done === 1'b1, "R5", 32'({done, good}), 2'b11);
    faultMask = '0;
    chk(good === 1'b1, "R7", 32'(good), 1);

    // R8: release returns to idle
    testMode = 1'b0;
    priIn = 8'h77;
    tick();
    chk(uutIn === 8'h77, "R8", 32'(uutIn), 32'h77);
    chk(done === 1'b0, "R8", 32'(done), 0);
    tick();

    // session 2: single-cycle response fault must fail
    testMode = 1'b1;
    waitRun();
    repeat (10) tick();
    faultMask = 6'h01;
    tick();
    faultMask = '0;
    waitDone();
    chk(done === 1'b1, "R6", 32'(done), 1);
    chk(good === 1'b0, "R5", 32'(good), 0);
    testMode = 1'b0;
    tick();

    // session 3: abort mid-window, then full restart
    testMode = 1'b1;
    waitRun();
    repeat (15) tick();
    testMode = 1'b0;
    priIn = 8'hA5;
    tick();
    chk(uutIn === 8'hA5, "R8", 32'(uutIn), 32'hA5);
    chk(genRun === 1'b0 && done === 1'b0, "R8", 32'({genRun, done}), 0);
    tick();
    testMode = 1'b1;
    tick();
    chk(genSeed === 1'b1, "R8", 32'(genSeed), 1);
    waitDone();
    chk(good === 1'b1, "R8", 32'(good), 1);
    repeat (3) tick();
    testMode = 1'b0;
    repeat (2) tick();
    finish();
  end

endmodule